// File: doc/BRIEF.md
# Partition Write Protection Unit

This unit decides, for a 19-bit array address, whether a pending write to a serial nonvolatile memory has to be refused. It sits behind a serial front end that shifts in commands, addresses and data bytes and turns them into one-cycle strobes. The unit owns eight partition registers and three protection flags: the partition write latch, the boundary lock and the freeze flag. The status register outside the unit supplies the write enable latch, the protection mode select and the two legacy block-protect bits. The write-protect pin comes in already synchronised.

In enhanced mode the array is divided by ordered endpoint registers, and the first one that reaches the address decides. In legacy mode two bits select a quarter, a half or all of the array. Configuration commands take effect only while both write latches are set and the configuration has not been frozen. Each attempt drops both latches. Boundary lock and freeze also require fixed unlock codes.

Top module: `partWriteGuard`

## Requirements
- R1: After reset every partition register reads 00h, `prelOut`, `pabpOut` and `fmpcOut` are 0, and in enhanced mode no address is protected.
- R2: A partition register holds its behaviour in bits 7:6 and its endpoint A18:A13 in bits 5:0. Behaviour 00 is open, 01 protected, 10 protected only while `wpPinIn`=1, and 11 protected.
- R3: With `wpmIn`=1, registers are examined from index 0 upward. The first one whose endpoint (bits 5:0 followed by thirteen ones) is at or above the address decides. A register whose endpoint does not exceed a lower-numbered one therefore never decides. Addresses above every endpoint are open.
- R4: With `wpmIn`=0, `bpIn`=00 protects nothing, 01 protects 60000h..7FFFFh, 10 protects 40000h..7FFFFh and 11 protects everything.
- R5: `cmdPrelSet` sets `prelOut`. `cmdPrelClr` and `cmdSoftRst` clear it. A soft reset leaves `pabpOut`, `fmpcOut` and the registers unchanged.
- R6: `mprRdData` shows, in the same cycle, the register selected by address bits 18:16.
- R7: A register write (`cmdMprWrite`) stores `dataIn` into the register selected by bits 18:16, but only if `welIn`=1, `prelOut`=1 and `fmpcOut`=0.
- R8: Each `cmdMprWrite`, `cmdBoundLock` or `cmdFreeze` raises `welClr` in its strobe cycle and clears `prelOut` on the next edge, whether or not it took effect.
- R9: While `pabpOut`=1, a register write changes only bits 7:6.
- R10: A gated `cmdBoundLock` with address bits 15:0 = CC55h sets `pabpOut` for data FFh and clears it for data 00h. Any other data or address leaves it unchanged.
- R11: A gated `cmdFreeze` with address bits 15:0 = AA40h and data D2h sets `fmpcOut` for good. After that, register writes and boundary lock have no effect.
- R12: A register whose behaviour bits are 11 cannot be rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdPrelSet | input | 1 | Set partition write latch strobe |
| cmdPrelClr | input | 1 | Clear partition write latch strobe |
| cmdMprWrite | input | 1 | Partition register write strobe |
| cmdBoundLock | input | 1 | Boundary lock/unlock strobe |
| cmdFreeze | input | 1 | Freeze configuration strobe |
| cmdSoftRst | input | 1 | Software reset strobe |
| addr | input | 19 | Array address / command address bits |
| dataIn | input | 8 | Command data byte |
| welIn | input | 1 | Write enable latch from status register |
| wpmIn | input | 1 | 1 = enhanced partition mode, 0 = legacy mode |
| bpIn | input | 2 | Legacy block-protect bits |
| wpPinIn | input | 1 | Write-protect pin, 1 = asserted |
| writeProt | output | 1 | Write to `addr` must be refused |
| mprRdData | output | 8 | Selected partition register contents |
| welClr | output | 1 | Request to clear the write enable latch |
| prelOut | output | 1 | Partition write latch |
| pabpOut | output | 1 | Boundary lock flag |
| fmpcOut | output | 1 | Freeze flag |

## Verification
A programmed layout is probed at both edges of each partition. It contains an open region, a software-protected region, a pin-dependent region, a locked region, an out-of-order register that must never decide, and unused registers. Each point that depends on the pin is probed with the pin high and low, so an off-by-one in the endpoint compare can be told apart from a wrong behaviour decode. Legacy mode is probed one address below and at each block-protect boundary. The configuration commands are tried with each gate missing in turn, with wrong unlock codes and data bytes, and again after freezing. Each attempt is followed by a readback, so an ignored command can be told apart from one that was applied.

// File: rtl/partGuardPkg.sv
package partGuardPkg;
  localparam logic [15:0] BOUND_CODE  = 16'hCC55;
  localparam logic [15:0] FREEZE_CODE = 16'hAA40;
  localparam logic [7:0]  FREEZE_KEY  = 8'hD2;
  localparam logic [7:0]  BOUND_SET   = 8'hFF;
  localparam logic [7:0]  BOUND_CLR   = 8'h00;

  typedef enum logic [1:0] {
    PB_OPEN   = 2'b00,
    PB_SOFT   = 2'b01,
    PB_HWPIN  = 2'b10,
    PB_LOCKED = 2'b11
  } partBehav_e;

  typedef struct packed {
    logic mprWe;
    logic keepEnd;
  } ctrlStrb_t;
endpackage

// File: rtl/partGuardCtrl.sv
module partGuardCtrl
  import partGuardPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdPrelSet,
  input  logic        cmdPrelClr,
  input  logic        cmdMprWrite,
  input  logic        cmdBoundLock,
  input  logic        cmdFreeze,
  input  logic        cmdSoftRst,
  input  logic [15:0] addrLow,
  input  logic [7:0]  dataIn,
  input  logic        welIn,
  output ctrlStrb_t   strb,
  output logic        welClr,
  output logic        prel,
  output logic        pabp,
  output logic        fmpc
);
  logic cfgAttempt, cfgOk, boundOk, freezeOk;

  always_comb begin
    cfgAttempt    = cmdMprWrite | cmdBoundLock | cmdFreeze;
    cfgOk         = welIn & prel & ~fmpc;
    boundOk       = cmdBoundLock & cfgOk & (addrLow == BOUND_CODE);
    freezeOk      = cmdFreeze & cfgOk & (addrLow == FREEZE_CODE) & (dataIn == FREEZE_KEY);
    strb.mprWe    = cmdMprWrite & cfgOk;
    strb.keepEnd  = pabp;
    welClr        = cfgAttempt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prel <= 1'b0;
      pabp <= 1'b0;
      fmpc <= 1'b0;
    end else begin
      if (cfgAttempt || cmdPrelClr || cmdSoftRst) prel <= 1'b0;
      else if (cmdPrelSet)                         prel <= 1'b1;
      if (boundOk && dataIn == BOUND_SET)      pabp <= 1'b1;
      else if (boundOk && dataIn == BOUND_CLR) pabp <= 1'b0;
      if (freezeOk) fmpc <= 1'b1;
    end
  end

  // R11
  fmpc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fmpc |=> fmpc);
  // R10
  pabp_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pabp) |-> $past(cmdBoundLock && welIn && prel && !fmpc));
  // R8
  prel_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdMprWrite || cmdBoundLock || cmdFreeze) |=> !prel);
endmodule

// File: rtl/partGuardRegs.sv
module partGuardRegs
  import partGuardPkg::*;
#(
  parameter int NUM_PART = 8,
  parameter int ADDR_W   = 19,
  parameter int REG_W    = 8,
  localparam int IDX_W   = $clog2(NUM_PART)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrb_t                       strb,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [REG_W-1:0]                dataIn,
  output logic [NUM_PART-1:0][REG_W-1:0]  mprAll,
  output logic [REG_W-1:0]                mprRdData
);
  logic [IDX_W-1:0] selIdx;
  assign selIdx    = addr[ADDR_W-1 -: IDX_W];
  assign mprRdData = mprAll[selIdx];

  for (genvar i = 0; i < NUM_PART; i++) begin : g_part
    logic hitWe, isLocked;
    assign hitWe    = strb.mprWe && (selIdx == IDX_W'(i));
    assign isLocked = (mprAll[i][REG_W-1 -: 2] == PB_LOCKED);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mprAll[i] <= '0;
      end else if (hitWe && !isLocked) begin
        if (strb.keepEnd) mprAll[i][REG_W-1 -: 2] <= dataIn[REG_W-1 -: 2];
        else              mprAll[i]               <= dataIn;
      end
    end

    // R12
    locked_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (mprAll[i][REG_W-1 -: 2] == 2'b11) |=> $stable(mprAll[i]));
    // R7
    mpr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(mprAll[i]) |-> $past(strb.mprWe));
    // R9
    keep_end_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.keepEnd |=> $stable(mprAll[i][REG_W-3:0]));
  end
endmodule

// File: rtl/partGuardScan.sv
module partGuardScan
  import partGuardPkg::*;
#(
  parameter int NUM_PART = 8,
  parameter int ADDR_W   = 19,
  parameter int REG_W    = 8,
  parameter int END_W    = 6
) (
  input  logic [NUM_PART-1:0][REG_W-1:0] mprAll,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wpmIn,
  input  logic [1:0]                     bpIn,
  input  logic                           wpPinIn,
  output logic                           writeProt
);
  logic [END_W-1:0]    addrHi;
  logic [NUM_PART-1:0] covers;
  logic [NUM_PART-1:0] guards;
  logic                enhProt, legProt;

  assign addrHi = addr[ADDR_W-1 -: END_W];

  for (genvar i = 0; i < NUM_PART; i++) begin : g_cmp
    partBehav_e behav;
    assign behav     = partBehav_e'(mprAll[i][REG_W-1 -: 2]);
    assign covers[i] = (addrHi <= mprAll[i][END_W-1:0]);
    always_comb begin
      unique case (behav)
        PB_OPEN:   guards[i] = 1'b0;
        PB_SOFT:   guards[i] = 1'b1;
        PB_HWPIN:  guards[i] = wpPinIn;
        PB_LOCKED: guards[i] = 1'b1;
      endcase
    end
  end

  // First covering register wins: scan from the top down so index 0 ends last.
  always_comb begin
    enhProt = 1'b0;
    for (int k = NUM_PART - 1; k >= 0; k--) begin
      if (covers[k]) enhProt = guards[k];
    end
  end

  always_comb begin
    unique case (bpIn)
      2'b00: legProt = 1'b0;
      2'b01: legProt = (addr[ADDR_W-1 -: 2] == 2'b11);
      2'b10: legProt = addr[ADDR_W-1];
      2'b11: legProt = 1'b1;
    endcase
  end

  assign writeProt = wpmIn ? enhProt : legProt;
endmodule

// File: rtl/partWriteGuard.sv
module partWriteGuard
  import partGuardPkg::*;
#(
  parameter int NUM_PART = 8,
  parameter int ADDR_W   = 19,
  parameter int REG_W    = 8,
  localparam int END_W   = REG_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdPrelSet,
  input  logic              cmdPrelClr,
  input  logic              cmdMprWrite,
  input  logic              cmdBoundLock,
  input  logic              cmdFreeze,
  input  logic              cmdSoftRst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  dataIn,
  input  logic              welIn,
  input  logic              wpmIn,
  input  logic [1:0]        bpIn,
  input  logic              wpPinIn,
  output logic              writeProt,
  output logic [REG_W-1:0]  mprRdData,
  output logic              welClr,
  output logic              prelOut,
  output logic              pabpOut,
  output logic              fmpcOut
);
  ctrlStrb_t                      strb;
  logic [NUM_PART-1:0][REG_W-1:0] mprAll;

  partGuardCtrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdPrelSet(cmdPrelSet), .cmdPrelClr(cmdPrelClr), .cmdMprWrite(cmdMprWrite),
    .cmdBoundLock(cmdBoundLock), .cmdFreeze(cmdFreeze), .cmdSoftRst(cmdSoftRst),
    .addrLow(addr[15:0]), .dataIn(dataIn), .welIn(welIn),
    .strb(strb), .welClr(welClr), .prel(prelOut), .pabp(pabpOut), .fmpc(fmpcOut)
  );

  partGuardRegs #(.NUM_PART(NUM_PART), .ADDR_W(ADDR_W), .REG_W(REG_W)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .mprAll(mprAll), .mprRdData(mprRdData)
  );

  partGuardScan #(.NUM_PART(NUM_PART), .ADDR_W(ADDR_W), .REG_W(REG_W), .END_W(END_W)) i_scan (
    .mprAll(mprAll), .addr(addr), .wpmIn(wpmIn), .bpIn(bpIn),
    .wpPinIn(wpPinIn), .writeProt(writeProt)
  );

  // R4
  legacy_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wpmIn && bpIn == 2'b11) |-> writeProt);
  // R4
  legacy_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wpmIn && bpIn == 2'b00) |-> !writeProt);
endmodule

// File: tb/test_partWriteGuard.sv
module test_partWriteGuard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdPrelSet = 0, cmdPrelClr = 0, cmdMprWrite = 0;
  logic        cmdBoundLock = 0, cmdFreeze = 0, cmdSoftRst = 0;
  logic [18:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        welIn = 0, wpmIn = 1, wpPinIn = 0;
  logic [1:0]  bpIn = '0;
  logic        writeProt, welClr, prelOut, pabpOut, fmpcOut;
  logic [7:0]  mprRdData;

  int checks = 0;
  int failures = 0;
  logic lastWelClr;

  always #2 clk = ~clk;

  partWriteGuard i_partWriteGuard (
    .clk(clk), .rstN(rstN),
    .cmdPrelSet(cmdPrelSet), .cmdPrelClr(cmdPrelClr), .cmdMprWrite(cmdMprWrite),
    .cmdBoundLock(cmdBoundLock), .cmdFreeze(cmdFreeze), .cmdSoftRst(cmdSoftRst),
    .addr(addr), .dataIn(dataIn), .welIn(welIn), .wpmIn(wpmIn), .bpIn(bpIn),
    .wpPinIn(wpPinIn), .writeProt(writeProt), .mprRdData(mprRdData),
    .welClr(welClr), .prelOut(prelOut), .pabpOut(pabpOut), .fmpcOut(fmpcOut)
  );

  // {wpm, bp[1:0], wp, addr[18:0], expected}
  localparam int NVEC = 18;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 1'b0, 19'h00000, 1'b1},
    {1'b1, 2'd0, 1'b0, 19'h03FFF, 1'b1},
    {1'b1, 2'd0, 1'b0, 19'h04000, 1'b0},
    {1'b1, 2'd0, 1'b1, 19'h07FFF, 1'b0},
    {1'b1, 2'd0, 1'b0, 19'h08000, 1'b0},
    {1'b1, 2'd0, 1'b1, 19'h08000, 1'b1},
    {1'b1, 2'd0, 1'b1, 19'h0FFFF, 1'b1},
    {1'b1, 2'd0, 1'b0, 19'h10000, 1'b1},
    {1'b1, 2'd0, 1'b1, 19'h1FFFF, 1'b1},
    {1'b1, 2'd0, 1'b0, 19'h20000, 1'b0},
    {1'b1, 2'd0, 1'b1, 19'h7FFFF, 1'b0},
    {1'b0, 2'd0, 1'b0, 19'h7FFFF, 1'b0},
    {1'b0, 2'd1, 1'b0, 19'h5FFFF, 1'b0},
    {1'b0, 2'd1, 1'b0, 19'h60000, 1'b1},
    {1'b0, 2'd2, 1'b0, 19'h3FFFF, 1'b0},
    {1'b0, 2'd2, 1'b0, 19'h40000, 1'b1},
    {1'b0, 2'd3, 1'b0, 19'h00000, 1'b1},
    {1'b0, 2'd3, 1'b1, 19'h12345, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 prelSet, 1 prelClr, 2 mprWrite, 3 boundLock, 4 freeze, 5 softRst
  task automatic cmd(input int kind, input logic [18:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    addr = a; dataIn = d; welIn = w;
    cmdPrelSet   = (kind == 0);
    cmdPrelClr   = (kind == 1);
    cmdMprWrite  = (kind == 2);
    cmdBoundLock = (kind == 3);
    cmdFreeze    = (kind == 4);
    cmdSoftRst   = (kind == 5);
    #1 lastWelClr = welClr;
    @(negedge clk);
    {cmdPrelSet, cmdPrelClr, cmdMprWrite, cmdBoundLock, cmdFreeze, cmdSoftRst} = '0;
    welIn = 0;
  endtask

  task automatic readReg(input int idx, output logic [7:0] v);
    addr = {idx[2:0], 16'h0000};
    #1 v = mprRdData;
  endtask

  task automatic progReg(input int idx, input logic [7:0] val);
    cmd(0, '0, '0, 0);
    cmd(2, {idx[2:0], 16'h0000}, val, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 prel", prelOut, 0);
    check("R1 pabp", pabpOut, 0);
    check("R1 fmpc", fmpcOut, 0);
    for (int i = 0; i < 8; i++) begin
      readReg(i, v);
      check("R1 mpr reset", v, 0);
    end
    addr = 19'h00000; #1 check("R1 open low", writeProt, 0);
    addr = 19'h7FFFF; #1 check("R1 open high", writeProt, 0);

    // R5 latch set/clear
    cmd(0, '0, '0, 0);
    check("R5 prel set", prelOut, 1);
    cmd(1, '0, '0, 0);
    check("R5 prel clr", prelOut, 0);

    // R7 write gated by PREL; R8 welClr pulse
    cmd(2, 19'h10000, 8'h55, 1);
    check("R8 welClr pulse", lastWelClr, 1);
    readReg(1, v); check("R7 no prel ignored", v, 0);
    // R7 gated by WEL; R8 prel dropped after attempt
    cmd(0, '0, '0, 0);
    cmd(2, 19'h10000, 8'h55, 0);
    check("R8 prel dropped", prelOut, 0);
    readReg(1, v); check("R7 no wel ignored", v, 0);

    // program layout, R6 readback
    progReg(0, 8'h41);
    progReg(1, 8'h03);
    progReg(2, 8'h42);
    progReg(3, 8'h87);
    progReg(4, 8'hCF);
    readReg(0, v); check("R6 mpr0", v, 8'h41);
    readReg(2, v); check("R6 mpr2", v, 8'h42);
    readReg(3, v); check("R6 mpr3", v, 8'h87);
    readReg(4, v); check("R6 mpr4", v, 8'hCF);
    readReg(5, v); check("R6 mpr5", v, 8'h00);

    // R2 R3 R4 vector table
    for (int n = 0; n < NVEC; n++) begin
      @(negedge clk);
      wpmIn = VEC[n][23]; bpIn = VEC[n][22:21]; wpPinIn = VEC[n][20]; addr = VEC[n][19:1];
      #1 check(wpmIn ? "R2/R3 enhanced vector" : "R4 legacy vector", writeProt, VEC[n][0]);
    end
    wpmIn = 1; bpIn = 0; wpPinIn = 0;

    // R12 locked register keeps value
    progReg(4, 8'h00);
    readReg(4, v); check("R12 locked kept", v, 8'hCF);

    // R10 wrong code / wrong data
    cmd(0, '0, '0, 0);
    cmd(3, 19'h0CC54, 8'hFF, 1);
    check("R10 bad code", pabpOut, 0);
    cmd(0, '0, '0, 0);
    cmd(3, 19'h0CC55, 8'h12, 1);
    check("R10 bad data", pabpOut, 0);
    cmd(0, '0, '0, 0);
    cmd(3, 19'h7CC55, 8'hFF, 1);
    check("R10 set", pabpOut, 1);
    check("R8 prel after bound", prelOut, 0);

    // R9 endpoint kept while locked
    progReg(1, 8'h7F);
    readReg(1, v); check("R9 keep end", v, 8'h43);
    cmd(0, '0, '0, 0);
    cmd(3, 19'h0CC55, 8'h00, 1);
    check("R10 clear", pabpOut, 0);

    // R11 freeze
    cmd(0, '0, '0, 0);
    cmd(4, 19'h0AA40, 8'hD1, 1);
    check("R11 bad key", fmpcOut, 0);
    cmd(0, '0, '0, 0);
    cmd(4, 19'h0AA41, 8'hD2, 1);
    check("R11 bad code", fmpcOut, 0);
    cmd(0, '0, '0, 0);
    cmd(4, 19'h0AA40, 8'hD2, 1);
    check("R11 frozen", fmpcOut, 1);
    progReg(5, 8'h3F);
    readReg(5, v); check("R11 write blocked", v, 8'h00);
    cmd(0, '0, '0, 0);
    cmd(3, 19'h0CC55, 8'hFF, 1);
    check("R11 bound blocked", pabpOut, 0);

    // R5 soft reset clears only prel
    cmd(0, '0, '0, 0);
    cmd(5, '0, '0, 0);
    check("R5 softrst prel", prelOut, 0);
    check("R5 softrst fmpc kept", fmpcOut, 1);
    readReg(0, v); check("R5 softrst mpr kept", v, 8'h41);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule